// File: doc/BRIEF.md
# Synthesizer Output Clock Divider

This block takes the high-speed oscillator clock of a frequency synthesizer and produces the output clock at the oscillator rate divided by 1, 2, 4 or 8. A two-bit ratio code selects the ratio. An active-high enable turns the output on and off. For the even ratios the output is a registered square wave with exactly 50% duty. For divide-by-1 the oscillator clock passes through a clock gate whose control is held in a latch that is transparent only while the clock is low.

The output is built one period at a time. A period starts when an internal counter wraps back to zero. The ratio code and the enable are taken up only at that point, so no output period ever mixes two ratios. Switching on, switching off or changing the ratio therefore never shortens a high or low pulse. The enable input is asynchronous to the oscillator and passes through a short synchronizer first. The ratio code is a static configuration input and is sampled directly. There is no data stream, so every pin is plain control.

Top module: `synth_out_divider`

## Requirements
- R1: An active-low asynchronous reset forces `clk_out` low at once. It clears the period counter, turns the output off and selects the divide-by-1 code internally, so that the first rising edge after reset is a period boundary.
- R2: `div_code` selects the ratio: 2'b00 divides by 2, 2'b01 by 4, 2'b10 by 8 and 2'b11 by 1. Over 64 oscillator cycles of steady operation, `clk_out` shows 64 divided by the ratio rising edges.
- R3: For ratio R in {2,4,8}, `clk_out` rises with the oscillator rising edge that starts a period. It stays high for exactly R/2 oscillator cycles and low for the remaining R/2.
- R4: A new `div_code` takes effect only at the next period boundary. The period in progress completes at its old length.
- R5: With the synchronized enable low at a boundary, `clk_out` stays low for the whole next period. A high phase already under way is never cut short.
- R6: A rising `out_en` reaches the divider after SYNC_STAGES oscillator edges. The output then starts at the next period boundary with a full-length high phase.
- R7: In divide-by-1 mode with the output on, `clk_out` follows the oscillator clock: high in each high half and low in each low half. The gate control changes only while the oscillator clock is low.
- R8: Switching between divide-by-1 and an even ratio, in either direction, yields only whole high and low phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vco_clk | input | 1 | High-speed oscillator clock; all state advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_code | input | 2 | Ratio code: 00 = /2, 01 = /4, 10 = /8, 11 = /1 |
| out_en | input | 1 | Active-high output enable, asynchronous to `vco_clk` |
| clk_out | output | 1 | Divided or passed-through output clock |

## Verification
Two events can land on the same oscillator edge: a period boundary that adopts a new ratio code, and a boundary that adopts a change of the enable. The most delicate case is a ratio change into or out of divide-by-1, where the latch and the registered output hand over control.

The bench sweeps every pair of old and new ratio codes. It applies the code change at each of eight cycle offsets inside a period, then toggles the enable soon after, so that both updates fall on the same or on neighbouring boundaries. It samples the output once in every oscillator high half and once in every low half. Each sample is judged against an arithmetic per-edge model of the requirements. Any clipped pulse shows up as a mismatched sample.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

  localparam int MAX_RATIO = 8;
  localparam int CNT_W     = $clog2(MAX_RATIO);

  typedef enum logic [1:0] {
    DIV2 = 2'b00,
    DIV4 = 2'b01,
    DIV8 = 2'b10,
    DIV1 = 2'b11
  } div_code_e;

  function automatic logic [CNT_W:0] ratio_of(input div_code_e c);
    case (c)
      DIV2:    ratio_of = (CNT_W+1)'(2);
      DIV4:    ratio_of = (CNT_W+1)'(4);
      DIV8:    ratio_of = (CNT_W+1)'(8);
      default: ratio_of = (CNT_W+1)'(1);
    endcase
  endfunction

endpackage

// File: rtl/sd_en_sync.sv
module sd_en_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/sd_period_ctrl.sv
module sd_period_ctrl
  import synth_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       code_in,
  input  logic             en_sync,
  output logic [CNT_W-1:0] cnt_q,
  output div_code_e        code_q,
  output logic             run_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output div_code_e        code_nxt,
  output logic             run_nxt
);

  logic wrap;

  // A period ends when the counter reaches ratio-1 for the active code.
  assign wrap = ({1'b0, cnt_q} == (ratio_of(code_q) - 1'b1));

  always_comb begin
    if (wrap) begin
      cnt_nxt  = '0;
      code_nxt = div_code_e'(code_in);
      run_nxt  = en_sync;
    end else begin
      cnt_nxt  = cnt_q + 1'b1;
      code_nxt = code_q;
      run_nxt  = run_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      code_q <= DIV1;
      run_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      code_q <= code_nxt;
      run_q  <= run_nxt;
    end
  end

  // R3: counter stays inside the active period
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cnt_q} < ratio_of(code_q)));

  // R4: ratio code only moves on a period boundary
  p_code_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> $stable(code_q));

  // R5: enable state only moves on a period boundary
  p_run_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> $stable(run_q));

endmodule

// File: rtl/sd_out_stage.sv
module sd_out_stage
  import synth_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  div_code_e        code_nxt,
  input  logic             run_nxt,
  output logic             div_q,
  output logic             gate_q,
  output logic             clk_out
);

  logic [CNT_W:0] half_nxt;
  logic           even_hi_nxt;
  logic           pass_nxt;

  assign half_nxt    = ratio_of(code_nxt) >> 1;
  assign even_hi_nxt = run_nxt && (code_nxt != DIV1) && ({1'b0, cnt_nxt} < half_nxt);
  assign pass_nxt    = run_nxt && (code_nxt == DIV1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= 1'b0;
    else        div_q <= even_hi_nxt;
  end

  // Gate control follows the next-cycle decision while the clock is low and
  // holds through the high half, so a passed pulse is always whole.
  always_latch begin
    if (!rst_n)   gate_q = 1'b0;
    else if (!clk) gate_q = pass_nxt;
  end

  assign clk_out = (clk & gate_q) | div_q;

endmodule

// File: rtl/synth_out_divider.sv
module synth_out_divider
  import synth_div_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       vco_clk,
  input  logic       rst_n,
  input  logic [1:0] div_code,
  input  logic       out_en,
  output logic       clk_out
);

  logic             en_sync;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  div_code_e        code_q;
  div_code_e        code_nxt;
  logic             run_q;
  logic             run_nxt;
  logic             div_q;
  logic             gate_q;

  sd_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (vco_clk),
    .rst_n (rst_n),
    .d     (out_en),
    .q     (en_sync)
  );

  sd_period_ctrl u_ctrl (
    .clk      (vco_clk),
    .rst_n    (rst_n),
    .code_in  (div_code),
    .en_sync  (en_sync),
    .cnt_q    (cnt_q),
    .code_q   (code_q),
    .run_q    (run_q),
    .cnt_nxt  (cnt_nxt),
    .code_nxt (code_nxt),
    .run_nxt  (run_nxt)
  );

  sd_out_stage u_out (
    .clk      (vco_clk),
    .rst_n    (rst_n),
    .cnt_nxt  (cnt_nxt),
    .code_nxt (code_nxt),
    .run_nxt  (run_nxt),
    .div_q    (div_q),
    .gate_q   (gate_q),
    .clk_out  (clk_out)
  );

  // R5: output held low while disabled
  p_off_low_r5: assert property (@(posedge vco_clk) disable iff (!rst_n)
    !run_q |-> !div_q);

  // R6: the divided output only rises at the start of a period
  p_rise_start_r6: assert property (@(posedge vco_clk) disable iff (!rst_n)
    $rose(div_q) |-> (cnt_q == '0));

  // R3: the divided output falls exactly at the half-count point
  p_fall_half_r3: assert property (@(posedge vco_clk) disable iff (!rst_n)
    $fell(div_q) |-> ({1'b0, cnt_q} == (ratio_of(code_q) >> 1)));

  // R8: pass-through gate and registered output never overlap
  p_gate_excl_r8: assert property (@(negedge vco_clk) disable iff (!rst_n)
    !(gate_q && div_q));

  // R7: in divide-by-1 the registered path stays quiet
  p_div1_quiet_r7: assert property (@(posedge vco_clk) disable iff (!rst_n)
    (code_q == DIV1) |-> !div_q);

endmodule

// File: tb/synth_out_divider_tb.sv
module synth_out_divider_tb;

  localparam int T    = 8;
  localparam int SYNC = 2;

  logic       vco_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic [1:0] div_code = 2'b00;
  logic       out_en  = 1'b0;
  logic       clk_out;

  int n_cmp  = 0;
  int n_bad  = 0;
  bit chk_en = 1'b0;
  string tag = "R1";
  int rise_cnt = 0;
  logic prev_s = 1'b0;

  // model state
  int m_cnt = 0;
  int m_code = 3;
  bit m_run = 0;
  bit m_div = 0;
  bit m_gate = 0;
  bit [SYNC-1:0] m_sync = '0;

  synth_out_divider #(.SYNC_STAGES(SYNC)) u_dut (
    .vco_clk  (vco_clk),
    .rst_n    (rst_n),
    .div_code (div_code),
    .out_en   (out_en),
    .clk_out  (clk_out)
  );

  always #(T/2) vco_clk = ~vco_clk;

  function automatic int ratio(input int c);
    case (c)
      0: ratio = 2;
      1: ratio = 4;
      2: ratio = 8;
      default: ratio = 1;
    endcase
  endfunction

  task automatic check(input string t, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", t, $time, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // per-edge arithmetic model and two samples per oscillator cycle
  always @(posedge vco_clk) begin
    bit oe_old;
    if (!rst_n) begin
      m_cnt = 0; m_code = 3; m_run = 0; m_div = 0; m_gate = 0; m_sync = '0;
    end else begin
      oe_old = m_sync[SYNC-1];
      m_sync = {m_sync[SYNC-2:0], out_en};
      if (m_cnt == ratio(m_code) - 1) begin
        m_cnt = 0; m_code = int'(div_code); m_run = oe_old;
      end else begin
        m_cnt = m_cnt + 1;
      end
      m_div  = m_run && (m_code != 3) && (m_cnt < ratio(m_code) / 2);
      m_gate = m_run && (m_code == 3);
    end
    #(T/4);
    if (chk_en) check(tag, clk_out, m_div | m_gate);
    if (clk_out && !prev_s) rise_cnt++;
    prev_s = clk_out;
    @(negedge vco_clk);
    #(T/4);
    if (chk_en) check(tag, clk_out, m_div);
    if (clk_out && !prev_s) rise_cnt++;
    prev_s = clk_out;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge vco_clk);
    #1;
  endtask

  initial begin
    #(T * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // R1: output low under reset and while disabled afterwards
    #(T/4);
    check("R1", clk_out, 1'b0);
    cyc(3);
    check("R1", clk_out, 1'b0);
    rst_n = 1'b1;
    tag = "R1";
    chk_en = 1'b1;
    cyc(6);

    // R2: rising-edge count per ratio over 64 cycles
    for (int c = 0; c < 4; c++) begin
      div_code = 2'(c);
      out_en = 1'b1;
      tag = (c == 3) ? "R7" : "R3";
      cyc(24);
      rise_cnt = 0;
      cyc(64);
      check("R2", (rise_cnt == 64 / ratio(c)), 1'b1);
      if (rise_cnt != 64 / ratio(c))
        $display("FAIL R2 code=%0d rises actual=%0d expected=%0d", c, rise_cnt, 64 / ratio(c));
    end

    // sweep of old code, new code and change offset
    for (int c1 = 0; c1 < 4; c1++) begin
      for (int c2 = 0; c2 < 4; c2++) begin
        for (int off = 0; off < 8; off++) begin
          div_code = 2'(c1);
          out_en = 1'b1;
          tag = (c1 == 3) ? "R7" : "R3";
          cyc(24 + off);
          div_code = 2'(c2);
          tag = (c1 == 3 || c2 == 3) ? "R8" : "R4";
          cyc(10);
          out_en = 1'b0;
          tag = "R5";
          cyc(12);
          out_en = 1'b1;
          tag = "R6";
          cyc(12);
        end
      end
    end

    // R1: asynchronous reset during a high phase
    div_code = 2'b10;
    out_en = 1'b1;
    tag = "R3";
    cyc(30);
    chk_en = 1'b0;
    @(posedge vco_clk);
    #1;
    rst_n = 1'b0;
    #1;
    check("R1", clk_out, 1'b0);
    cyc(3);
    check("R1", clk_out, 1'b0);
    rst_n = 1'b1;
    out_en = 1'b0;
    tag = "R1";
    chk_en = 1'b1;
    cyc(12);
    summary();
  end

endmodule